// File: doc/BRIEF.md
# Extended Indexed Effective-Address Calculator

This block works out the effective address of an operand that uses one of the indexed addressing modes carried by an extension word. A caller pulses a start input with the program counter value where the extension word sits and the 6-bit mode/register field of the operand. The block reads the extension word, then reads any base and outer displacements that follow it in the instruction stream. When the word asks for memory indirection it also reads a 32-bit pointer. It gets the base and index register values through two combinational read ports into the register files.

When it finishes, the block pulses exactly one of three outcomes. `done_o` comes with the final address and the number of instruction-stream bytes consumed. `fault_o` means a memory read was aborted. `illegal_o` means the indirection selector holds a reserved value. The caller's program counter is not changed: the consumed byte count is returned, and the caller advances its PC by that amount.

Top module: `ea_ext_calc`

## Requirements
- R1: After `start_i` in the idle state, the first memory read is a 16-bit read (`mem_long_o`=0) at `pc_i`. The base is that PC value when `mode_i[3]`=1, and otherwise the address register selected by `mode_i[2:0]`.
- R2: Extension word bit 15 picks the index register file (0 data, 1 address) and bits 14:12 pick the register. With bit 11 = 0 the low 16 bits are sign-extended; with bit 11 = 1 the whole register is used. The value is then shifted left by bits 10:9.
- R3: With bit 8 = 0 (short format), the address is base + sign-extended bits 7:0 + scaled index. Only the extension word is read, and the consumed length is 2.
- R4: With bit 8 = 1 (long format), bit 7 = 1 forces the base to zero and bit 6 = 1 forces the index to zero.
- R5: In long format, bits 5:4 = 2 read a sign-extended 16-bit base displacement and bits 5:4 = 3 read a 32-bit one, at PC+2. Values 0 and 1 read nothing, and the displacement is then zero.
- R6: Let S = {bit 6, bits 2:0}. S = 0010, 0110 or 1010 reads a sign-extended 16-bit outer displacement. S = 0011, 0111 or 1011 reads a 32-bit one. This read follows any base displacement in the instruction stream. Every other S gives an outer displacement of zero.
- R7: For S = 0001, 0010, 0011, 1001, 1010 or 1011, a 32-bit pointer is read at base + bd + index, and the address is pointer + od.
- R8: For S = 0101, 0110 or 0111, a 32-bit pointer is read at base + bd, and the address is pointer + index + od.
- R9: For S = 0000 or 1000, the address is base + bd + index, and no pointer read is made.
- R10: In long format, S = 0100 or S = 11xx pulses `illegal_o` after the extension word is read. No further memory read follows.
- R11: `mem_err_i` on any read pulses `fault_o` instead of `done_o`, ends the calculation and returns the block to idle.
- R12: `ext_len_o` is the number of extension and displacement bytes read (2 per 16-bit read, 4 per 32-bit read). The pointer read is not counted.
- R13: After reset the block is idle with no request. `start_i` while busy is ignored. A request holds its address and size until `mem_ack_i` or `mem_err_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calculation (taken only when idle) |
| pc_i | input | 32 | Address of the extension word |
| mode_i | input | 6 | Mode/register field; bit 3 selects PC-relative base |
| base_sel_o | output | 3 | Address register index for the base |
| base_data_i | input | 32 | Value of the selected base register |
| idx_sel_o | output | 4 | Index register: bit 3 file (1 = address), bits 2:0 number |
| idx_data_i | input | 32 | Value of the selected index register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Read address |
| mem_long_o | output | 1 | 1 = 32-bit read, 0 = 16-bit read (data in bits 15:0) |
| mem_ack_i | input | 1 | Read complete, data valid |
| mem_err_i | input | 1 | Read aborted |
| mem_data_i | input | 32 | Read data |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| fault_o | output | 1 | One-cycle pulse: a read aborted |
| illegal_o | output | 1 | One-cycle pulse: reserved selector value |
| ea_o | output | 32 | Final effective address |
| ext_len_o | output | 4 | Instruction-stream bytes consumed |

## Verification
The bench covers every legal indirection selector, including the ones that have bit 6 set and still indirect. A decoder that tied those to post-indexing would add the index after the pointer read, so both the pointer address and the result would be wrong.

Negative 16-bit indexes and displacements are used. A design that zero-extends them yields addresses that are off by 64 KiB.

Word reads return junk in bits 31:16. A design that uses those bits corrupts the displacements.

Faults are injected on the first, a middle and the last read. A design that keeps going after a fault makes an extra request or pulses `done_o`.

A second start during a calculation checks that the captured PC is not overwritten. Response latency varies from test to test, which catches a request whose address drifts while it waits.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {DISP_NONE, DISP_WORD, DISP_LONG} disp_e;
  typedef enum logic [1:0] {IND_NONE, IND_PRE, IND_POST} ind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_EXT, ST_DEC, ST_BD, ST_OD, ST_IND, ST_FIN} st_e;

  typedef struct packed {
    logic       idx_areg;
    logic [2:0] idx_reg;
    logic       idx_long;
    logic [1:0] scale;
    logic       full;
    logic       base_sup;
    logic       idx_sup;
    disp_e      bd;
    disp_e      od;
    ind_e       ind;
    logic       illegal;
  } ext_dec_t;
endpackage

// File: rtl/ea_ext_decode.sv
module ea_ext_decode
  import ea_pkg::*;
(
  input  logic [15:0] ext_i,
  output ext_dec_t    dec_o
);
  logic [3:0] sel;
  assign sel = {ext_i[6], ext_i[2:0]};

  always_comb begin
    dec_o          = '0;
    dec_o.idx_areg = ext_i[15];
    dec_o.idx_reg  = ext_i[14:12];
    dec_o.idx_long = ext_i[11];
    dec_o.scale    = ext_i[10:9];
    dec_o.full     = ext_i[8];
    dec_o.bd       = DISP_NONE;
    dec_o.od       = DISP_NONE;
    dec_o.ind      = IND_NONE;
    if (ext_i[8]) begin
      dec_o.base_sup = ext_i[7];
      dec_o.idx_sup  = ext_i[6];
      case (ext_i[5:4])
        2'd2:    dec_o.bd = DISP_WORD;
        2'd3:    dec_o.bd = DISP_LONG;
        default: dec_o.bd = DISP_NONE;
      endcase
      case (sel)
        4'b0000, 4'b1000: dec_o.ind = IND_NONE;
        4'b0001, 4'b1001: dec_o.ind = IND_PRE;
        4'b0010, 4'b1010: begin dec_o.ind = IND_PRE;  dec_o.od = DISP_WORD; end
        4'b0011, 4'b1011: begin dec_o.ind = IND_PRE;  dec_o.od = DISP_LONG; end
        4'b0101:          dec_o.ind = IND_POST;
        4'b0110:          begin dec_o.ind = IND_POST; dec_o.od = DISP_WORD; end
        4'b0111:          begin dec_o.ind = IND_POST; dec_o.od = DISP_LONG; end
        default:          dec_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ea_index_unit.sv
module ea_index_unit #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] reg_i,
  input  logic              long_i,
  input  logic [1:0]        scale_i,
  input  logic              sup_i,
  output logic [ADDR_W-1:0] idx_o
);
  logic [ADDR_W-1:0] raw;
  assign raw   = long_i ? reg_i : {{(ADDR_W-16){reg_i[15]}}, reg_i[15:0]};
  assign idx_o = sup_i ? '0 : (raw << scale_i);
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] data_i,
  input  logic              long_i,
  output logic [ADDR_W-1:0] val_o
);
  assign val_o = long_i ? data_i : {{(ADDR_W-16){data_i[15]}}, data_i[15:0]};
endmodule

// File: rtl/ea_ext_calc.sv
module ea_ext_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [5:0]        mode_i,
  output logic [2:0]        base_sel_o,
  input  logic [ADDR_W-1:0] base_data_i,
  output logic [3:0]        idx_sel_o,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_long_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [ADDR_W-1:0] mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              illegal_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [LEN_W-1:0]  ext_len_o
);
  localparam int MAX_LEN = 10;

  st_e               st_q;
  logic [ADDR_W-1:0] pc_q, base_q, idx_q, bd_q, od_q, ptr_q;
  logic              pcrel_q;
  logic [2:0]        base_reg_q;
  logic [15:0]       ext_q;
  logic [LEN_W-1:0]  len_q;

  ext_dec_t          dec;
  logic [ADDR_W-1:0] idx_val, disp_val, brief_disp;
  st_e               after_bd, after_od, after_dec;
  logic [LEN_W-1:0]  len_step;

  ea_ext_decode u_dec (.ext_i(ext_q), .dec_o(dec));

  ea_index_unit #(.ADDR_W(ADDR_W)) u_idx (
    .reg_i(idx_data_i), .long_i(dec.idx_long), .scale_i(dec.scale),
    .sup_i(dec.idx_sup), .idx_o(idx_val)
  );

  ea_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
    .data_i(mem_data_i), .long_i(mem_long_o), .val_o(disp_val)
  );

  assign base_sel_o = base_reg_q;
  assign idx_sel_o  = {dec.idx_areg, dec.idx_reg};
  assign busy_o     = (st_q != ST_IDLE);
  assign brief_disp = {{(ADDR_W-8){ext_q[7]}}, ext_q[7:0]};
  assign len_step   = mem_long_o ? LEN_W'(4) : LEN_W'(2);

  always_comb begin
    after_od  = (dec.ind != IND_NONE) ? ST_IND : ST_FIN;
    after_bd  = (dec.od != DISP_NONE) ? ST_OD : after_od;
    if (!dec.full)               after_dec = ST_FIN;
    else if (dec.illegal)        after_dec = ST_IDLE;
    else if (dec.bd != DISP_NONE) after_dec = ST_BD;
    else                         after_dec = after_bd;
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_long_o = 1'b0;
    mem_addr_o = pc_q;
    case (st_q)
      ST_EXT: mem_req_o = 1'b1;
      ST_BD: begin
        mem_req_o  = 1'b1;
        mem_long_o = (dec.bd == DISP_LONG);
        mem_addr_o = pc_q + ADDR_W'(len_q);
      end
      ST_OD: begin
        mem_req_o  = 1'b1;
        mem_long_o = (dec.od == DISP_LONG);
        mem_addr_o = pc_q + ADDR_W'(len_q);
      end
      ST_IND: begin
        mem_req_o  = 1'b1;
        mem_long_o = 1'b1;
        mem_addr_o = base_q + bd_q + ((dec.ind == IND_PRE) ? idx_q : '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pc_q       <= '0;
      pcrel_q    <= 1'b0;
      base_reg_q <= '0;
      ext_q      <= '0;
      len_q      <= '0;
      base_q     <= '0;
      idx_q      <= '0;
      bd_q       <= '0;
      od_q       <= '0;
      ptr_q      <= '0;
      ea_o       <= '0;
      ext_len_o  <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      fault_o   <= 1'b0;
      illegal_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          pc_q       <= pc_i;
          pcrel_q    <= mode_i[3];
          base_reg_q <= mode_i[2:0];
          len_q      <= '0;
          st_q       <= ST_EXT;
        end
        ST_EXT, ST_BD, ST_OD, ST_IND: begin
          if (mem_err_i) begin
            fault_o <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (mem_ack_i) begin
            case (st_q)
              ST_EXT: begin
                ext_q <= mem_data_i[15:0];
                len_q <= len_q + len_step;
                st_q  <= ST_DEC;
              end
              ST_BD: begin
                bd_q  <= disp_val;
                len_q <= len_q + len_step;
                st_q  <= after_bd;
              end
              ST_OD: begin
                od_q  <= disp_val;
                len_q <= len_q + len_step;
                st_q  <= after_od;
              end
              default: begin
                ptr_q <= mem_data_i;
                st_q  <= ST_FIN;
              end
            endcase
          end
        end
        ST_DEC: begin
          if (dec.full && dec.base_sup) base_q <= '0;
          else                          base_q <= pcrel_q ? pc_q : base_data_i;
          idx_q     <= idx_val;
          bd_q      <= dec.full ? '0 : brief_disp;
          od_q      <= '0;
          illegal_o <= dec.illegal;
          st_q      <= after_dec;
        end
        ST_FIN: begin
          if (dec.ind == IND_NONE) ea_o <= base_q + bd_q + idx_q;
          else ea_o <= ptr_q + od_q + ((dec.ind == IND_POST) ? idx_q : '0);
          ext_len_o <= len_q;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_ext_word_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !$past(busy_o)) |-> (!mem_long_o && mem_addr_o == pc_q));

  p_brief_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ext_q[8]) |-> (ext_len_o == LEN_W'(2)));

  p_illegal_no_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_req_o && !busy_o));

  p_one_outcome_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fault_o, illegal_o}));

  p_fault_stops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!busy_o && !mem_req_o));

  p_len_bound_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ext_len_o[0] && ext_len_o <= LEN_W'(MAX_LEN)));

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !mem_err_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_long_o)));

  p_start_ignored_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(pc_q));
endmodule

// File: tb/sim_ea_ext_calc.sv
`timescale 1ns/1ps
module sim_ea_ext_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pc = '0;
  logic [5:0]  mode = '0;
  logic [2:0]  base_sel;
  logic [31:0] base_data;
  logic [3:0]  idx_sel;
  logic [31:0] idx_data;
  logic        mem_req, mem_long;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_data = '0;
  logic        busy, done, fault, illegal;
  logic [31:0] ea;
  logic [3:0]  ext_len;

  always #2.5 clk = ~clk;

  ea_ext_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pc_i(pc), .mode_i(mode),
    .base_sel_o(base_sel), .base_data_i(base_data),
    .idx_sel_o(idx_sel), .idx_data_i(idx_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_long_o(mem_long),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_data_i(mem_data),
    .busy_o(busy), .done_o(done), .fault_o(fault), .illegal_o(illegal),
    .ea_o(ea), .ext_len_o(ext_len)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] dr [8];
  logic [31:0] ar [8];
  assign base_data = ar[base_sel];
  assign idx_data  = idx_sel[3] ? ar[idx_sel[2:0]] : dr[idx_sel[2:0]];

  logic [7:0] mem_b [bit [31:0]];

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    if (mem_b.exists(a)) return mem_b[a];
    return a[7:0] ^ a[15:8] ^ 8'h3c;
  endfunction
  function automatic logic [15:0] rd_word(input logic [31:0] a);
    return {rd_byte(a), rd_byte(a + 1)};
  endfunction
  function automatic logic [31:0] rd_long(input logic [31:0] a);
    return {rd_word(a), rd_word(a + 2)};
  endfunction
  task automatic wr_word(input logic [31:0] a, input logic [15:0] v);
    mem_b[a] = v[15:8]; mem_b[a + 1] = v[7:0];
  endtask
  task automatic wr_long(input logic [31:0] a, input logic [31:0] v);
    wr_word(a, v[31:16]); wr_word(a + 2, v[15:0]);
  endtask
  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // expected read sequence: {long, addr}
  logic [32:0] exp_q [$];
  int m_n, err_idx, r_n, lat, wcnt;
  string cur_tag;

  function automatic bit acc(input logic [31:0] a, input bit lng);
    exp_q.push_back({lng, a});
    m_n++;
    return (m_n - 1) == err_idx;
  endfunction

  always @(negedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (rst_n && mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (exp_q.size() == 0) begin
          chk({cur_tag, " unexpected read"}, mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk({cur_tag, " read addr"}, mem_addr, e[31:0]);
          chk({cur_tag, " read size"}, {31'd0, mem_long}, {31'd0, e[32]});
        end
        if (r_n == err_idx) mem_err <= 1'b1;
        else begin
          mem_ack  <= 1'b1;
          mem_data <= mem_long ? rd_long(mem_addr) : {16'hDEAD, rd_word(mem_addr)};
        end
        r_n++;
      end else wcnt++;
    end else wcnt = 0;
  end

  // kind: 0 done, 1 fault, 2 illegal
  task automatic model(input logic [31:0] p, input logic [5:0] md,
                       output int kind, output logic [31:0] x_ea, output int x_len);
    logic [15:0] e;
    logic [31:0] base, rv, ix, bd, od, ptr, ia;
    logic [3:0]  s;
    bit f;
    exp_q.delete();
    m_n = 0; kind = 0; x_ea = '0; x_len = 0;
    if (acc(p, 0)) begin kind = 1; return; end
    e = rd_word(p); x_len = 2;
    base = md[3] ? p : ar[md[2:0]];
    rv = e[15] ? ar[e[14:12]] : dr[e[14:12]];
    ix = (e[11] ? rv : sx16(rv[15:0])) << e[10:9];
    if (!e[8]) begin
      x_ea = base + {{24{e[7]}}, e[7:0]} + ix;
      return;
    end
    s = {e[6], e[2:0]};
    if (s == 4'b0100 || s[3:2] == 2'b11) begin kind = 2; return; end
    if (e[7]) base = '0;
    if (e[6]) ix = '0;
    bd = '0; od = '0; f = 0;
    if (e[5:4] == 2'd2) begin
      f = acc(p + x_len, 0); bd = sx16(rd_word(p + x_len)); x_len += 2;
    end else if (e[5:4] == 2'd3) begin
      f = acc(p + x_len, 1); bd = rd_long(p + x_len); x_len += 4;
    end
    if (f) begin kind = 1; return; end
    if (s[1:0] == 2'd2) begin
      f = acc(p + x_len, 0); od = sx16(rd_word(p + x_len)); x_len += 2;
    end else if (s[1:0] == 2'd3) begin
      f = acc(p + x_len, 1); od = rd_long(p + x_len); x_len += 4;
    end
    if (f) begin kind = 1; return; end
    if (s[2:0] == 3'b000) x_ea = base + bd + ix;
    else if (!s[2]) begin
      ia = base + bd + ix;
      if (acc(ia, 1)) begin kind = 1; return; end
      ptr = rd_long(ia); x_ea = ptr + od;
    end else begin
      ia = base + bd;
      if (acc(ia, 1)) begin kind = 1; return; end
      ptr = rd_long(ia); x_ea = ptr + ix + od;
    end
  endtask

  task automatic run(input string tag, input logic [31:0] p, input logic [5:0] md,
                     input int l, input int eidx, input bit restart);
    int kind, x_len, got, n;
    logic [31:0] x_ea;
    cur_tag = tag; lat = l; err_idx = eidx; r_n = 0;
    model(p, md, kind, x_ea, x_len);
    @(negedge clk);
    pc = p; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      @(negedge clk);
      pc = p + 32'h40; mode = ~md; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = -1; n = 0;
    while (got < 0 && n < 200) begin
      if (done) got = 0;
      else if (fault) got = 1;
      else if (illegal) got = 2;
      else begin @(negedge clk); n++; end
    end
    chk({tag, " outcome"}, got, kind);
    if (got == 0 && kind == 0) begin
      chk({tag, " address"}, ea, x_ea);
      chk({tag, " length"}, {28'd0, ext_len}, x_len);
    end
    chk({tag, " reads left"}, exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk({tag, " idle after"}, {30'd0, busy, mem_req}, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      ar[i] = 32'h1000_0000 + i * 32'h0001_0100;
      dr[i] = 32'h0000_0011 * (i + 1);
    end
    dr[3] = 32'h1234_FFF0;
    dr[5] = 32'h0001_2345;
    ar[4] = 32'h0000_8002;
    wcnt = 0; err_idx = -1; r_n = 0; lat = 0; cur_tag = "";
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 reset busy", {31'd0, busy}, 0);
    chk("R13 reset req", {31'd0, mem_req}, 0);
    chk("R13 reset outcome", {29'd0, done, fault, illegal}, 0);
    rst_n = 1'b1;

    wr_word(32'h0000_1000, 16'h34F8);
    run("R2 R3 short An base neg word index", 32'h0000_1000, 6'b110_010, 0, -1, 0);
    wr_word(32'h0000_1100, 16'h9E10);
    run("R1 R2 short pc base long index", 32'h0000_1100, 6'b111_011, 1, -1, 0);
    wr_word(32'h0000_1200, 16'h5BA0); wr_word(32'h0000_1202, 16'hFF00);
    run("R4 R5 R9 base suppressed word bd", 32'h0000_1200, 6'b110_001, 2, -1, 0);
    wr_word(32'h0000_1300, 16'hC170); wr_long(32'h0000_1302, 32'h0000_4000);
    run("R4 R5 R9 index suppressed long bd", 32'h0000_1300, 6'b110_110, 0, -1, 0);
    wr_word(32'h0000_1400, 16'h5911);
    run("R5 R7 pre null bd no od", 32'h0000_1400, 6'b110_011, 1, -1, 0);
    wr_word(32'h0000_1500, 16'h5922); wr_word(32'h0000_1502, 16'h0080); wr_word(32'h0000_1504, 16'hFFFC);
    run("R6 R7 pre word od", 32'h0000_1500, 6'b110_000, 0, -1, 0);
    wr_word(32'h0000_1600, 16'h5933); wr_long(32'h0000_1602, 32'h0002_0000); wr_long(32'h0000_1606, 32'h0000_0300);
    run("R6 R7 R12 pre long od", 32'h0000_1600, 6'b110_111, 2, -1, 0);
    wr_word(32'h0000_1700, 16'h5925); wr_word(32'h0000_1702, 16'h0010);
    run("R8 post no od", 32'h0000_1700, 6'b110_101, 0, -1, 0);
    wr_word(32'h0000_1800, 16'h5986); wr_word(32'h0000_1802, 16'h8000);
    run("R4 R8 post suppressed base word od", 32'h0000_1800, 6'b110_100, 1, -1, 0);
    wr_word(32'h0000_1900, 16'h5937); wr_long(32'h0000_1902, 32'h0000_0020); wr_long(32'h0000_1906, 32'hFFFF_FF00);
    run("R1 R8 R12 post pc base long od", 32'h0000_1900, 6'b111_011, 0, -1, 0);
    wr_word(32'h0000_1A00, 16'h5963); wr_word(32'h0000_1A02, 16'h0100);
    run("R7 pre with index suppressed", 32'h0000_1A00, 6'b110_010, 0, -1, 0);
    wr_word(32'h0000_1B00, 16'h5951);
    run("R7 sel 1001", 32'h0000_1B00, 6'b110_001, 1, -1, 0);
    wr_word(32'h0000_1C00, 16'h5942); wr_word(32'h0000_1C02, 16'h7FFE);
    run("R6 R7 sel 1010", 32'h0000_1C00, 6'b110_110, 0, -1, 0);
    wr_word(32'h0000_1D00, 16'h5904);
    run("R10 sel 0100", 32'h0000_1D00, 6'b110_000, 0, -1, 0);
    wr_word(32'h0000_1D10, 16'h5944);
    run("R10 sel 1100", 32'h0000_1D10, 6'b110_000, 1, -1, 0);
    wr_word(32'h0000_1D20, 16'h5947);
    run("R10 sel 1111", 32'h0000_1D20, 6'b110_000, 0, -1, 0);
    run("R11 fault on extension word", 32'h0000_1600, 6'b110_111, 0, 0, 0);
    run("R11 fault on base displacement", 32'h0000_1600, 6'b110_111, 1, 1, 0);
    run("R11 fault on pointer read", 32'h0000_1600, 6'b110_111, 0, 3, 0);
    run("R13 start ignored while busy", 32'h0000_1900, 6'b111_011, 2, -1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule